// File: doc/BRIEF.md
# GPIO Port Data Register

This block holds the 16-bit data word of one general-purpose I/O port with fifteen pins. Bits 14..0 each belong to one pin, and bit 15 is a reserved constant. A bus master writes the word one byte lane at a time through a single-cycle strobe. It reads the word back through a combinational path.

For each bit, the read path picks one of two sources:
- A pin configured as output returns the stored bit.
- A pin configured as input returns the pin level, after a two-flop synchronizer.

The per-pin direction vector comes from outside the block. So does a second vector that marks which pins are in general-purpose I/O function. A write always lands in the stored bits. The stored bit reaches the pad only where the pin is an output and is in general-purpose function.

The stored bits are cleared in three cases:
- an asynchronous power-on reset;
- a synchronous reset request that did not come from the watchdog;
- any cycle in hardware standby.

The stored bits are kept through a watchdog-caused reset, sleep and software standby.

Top module: `gpio_port_data`

## Requirements
- R1: After `rstN` is released, `rdData` reads 16'h8000 with all pins low, for either direction setting, and `pinOut` is 0.
- R2: `rdData[15]` always reads 1. Bit 15 of `wrData` has no effect on any output.
- R3: For each pin i, when `dirBits[i]`=1, `rdData[i]` returns the stored bit. When `dirBits[i]`=0, it returns the synchronized level of `pinIn[i]`.
- R4: When `wrEn`=1, `byteEn[0]`=1 writes stored bits 7..0 from `wrData[7:0]`. `byteEn[1]`=1 writes stored bits 14..8 from `wrData[14:8]`. A lane whose enable is 0 keeps its value.
- R5: `pinOut` equals the stored bits at all times. `pinOe[i]` = `dirBits[i]` AND `genFunc[i]`.
- R6: A write made while pins are inputs, or not in general function, leaves `pinOe` low. The written value is still stored and reads back once the pins become outputs.
- R7: A cycle with `resetReq`=1 and `resetIsWdt`=0 clears all stored bits at the next edge.
- R8: A cycle with `resetReq`=1 and `resetIsWdt`=1 leaves the stored bits unchanged.
- R9: `pwrMode`=2'b11 (hardware standby) clears the stored bits on every edge it is held. `pwrMode`=2'b01 (sleep) and 2'b10 (software standby) keep them. 2'b00 is normal run.
- R10: When a clear (R7 or R9) and a write fall in the same cycle, the clear wins and the stored bits become 0.
- R11: A change on `pinIn` is visible on `rdData` of an input pin after exactly two rising clock edges, not after one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| resetReq | input | 1 | Synchronous reset request |
| resetIsWdt | input | 1 | Marks `resetReq` as watchdog-caused |
| pwrMode | input | 2 | Power mode: 00 run, 01 sleep, 10 software standby, 11 hardware standby |
| wrEn | input | 1 | Single-cycle write strobe |
| byteEn | input | 2 | Byte lane enables, bit 0 for the low byte |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data |
| pinIn | input | 15 | Pin levels from the pads |
| dirBits | input | 15 | Direction per pin, 1 = output |
| genFunc | input | 15 | 1 = pin is in general-purpose I/O function |
| pinOut | output | 15 | Output value per pin |
| pinOe | output | 15 | Output enable per pin |

## Verification
A bus write and a clear can fall in the same cycle. The clear can come from a non-watchdog reset request or from hardware standby. The bench provokes this by raising `wrEn` with all lanes enabled in the same cycle as each clear source, writing a nonzero pattern. It judges the result by reading back 16'h8000 and seeing `pinOut` at zero. The same pairing with a watchdog reset request must instead show the written pattern.

// File: rtl/gpio_pdr_pkg.sv
package gpio_pdr_pkg;
  localparam int PDR_LANES = 2;
  localparam int PDR_REG_W = 8 * PDR_LANES;

  typedef enum logic [1:0] {
    PWR_RUN     = 2'b00,
    PWR_SLEEP   = 2'b01,
    PWR_SW_STBY = 2'b10,
    PWR_HW_STBY = 2'b11
  } pwrMode_e;

  typedef struct packed {
    logic [PDR_LANES-1:0] laneWr;
    logic                 clear;
  } pdrStrobe_t;
endpackage

// File: rtl/gpio_pdr_ctrl.sv
module gpio_pdr_ctrl
  import gpio_pdr_pkg::*;
(
  input  logic                 wrEn,
  input  logic [PDR_LANES-1:0] byteEn,
  input  logic                 resetReq,
  input  logic                 resetIsWdt,
  input  logic [1:0]           pwrMode,
  output pdrStrobe_t           strobe
);
  logic clearNow;

  always_comb begin
    clearNow      = (resetReq && !resetIsWdt) || (pwrMode == PWR_HW_STBY);
    strobe.clear  = clearNow;
    strobe.laneWr = (wrEn && !clearNow) ? byteEn : '0;
  end
endmodule

// File: rtl/gpio_pdr_dp.sv
module gpio_pdr_dp
  import gpio_pdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int REG_W      = PDR_REG_W,
  localparam int NUM_PINS   = REG_W - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  pdrStrobe_t          strobe,
  input  logic [NUM_PINS-1:0] wrBits,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] dirBits,
  input  logic [NUM_PINS-1:0] genFunc,
  output logic [REG_W-1:0]    rdData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  logic [NUM_PINS-1:0]                  dataQ;
  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (strobe.clear) begin
      dataQ <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (strobe.laneWr[i / 8]) dataQ[i] <= wrBits[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign rdData[g] = dirBits[g] ? dataQ[g] : syncQ[SYNC_STAGES-1][g];
    assign pinOe[g]  = dirBits[g] & genFunc[g];
  end
  assign rdData[REG_W-1] = 1'b1;
  assign pinOut          = dataQ;
endmodule

// File: rtl/gpio_port_data.sv
module gpio_port_data
  import gpio_pdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int REG_W      = PDR_REG_W,
  localparam int NUM_PINS   = REG_W - 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 resetReq,
  input  logic                 resetIsWdt,
  input  logic [1:0]           pwrMode,
  input  logic                 wrEn,
  input  logic [PDR_LANES-1:0] byteEn,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData,
  input  logic [NUM_PINS-1:0]  pinIn,
  input  logic [NUM_PINS-1:0]  dirBits,
  input  logic [NUM_PINS-1:0]  genFunc,
  output logic [NUM_PINS-1:0]  pinOut,
  output logic [NUM_PINS-1:0]  pinOe
);
  pdrStrobe_t strobe;

  gpio_pdr_ctrl u_ctrl (
    .wrEn      (wrEn),
    .byteEn    (byteEn),
    .resetReq  (resetReq),
    .resetIsWdt(resetIsWdt),
    .pwrMode   (pwrMode),
    .strobe    (strobe)
  );

  gpio_pdr_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrBits (wrData[NUM_PINS-1:0]),
    .pinIn  (pinIn),
    .dirBits(dirBits),
    .genFunc(genFunc),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinOe  (pinOe)
  );
endmodule

// File: rtl/gpio_pdr_chk.sv
module gpio_pdr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        resetReq,
  input logic        resetIsWdt,
  input logic [1:0]  pwrMode,
  input logic        wrEn,
  input logic [1:0]  byteEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic [14:0] dirBits,
  input logic [14:0] genFunc,
  input logic [14:0] pinOut,
  input logic [14:0] pinOe
);
  AST_RSVD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    rdData[15] == 1'b1); // R2

  AST_OUT_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    ((rdData[14:0] ^ pinOut) & dirBits) == 15'd0); // R3

  AST_OE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & ~(dirBits & genFunc)) == 15'd0); // R5

  AST_LOW_LANE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && byteEn[0] && !resetReq && pwrMode != 2'b11)
      |=> pinOut[7:0] == $past(wrData[7:0])); // R4

  AST_CLEAR_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && !resetIsWdt) |=> pinOut == 15'd0); // R7

  AST_WDT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && resetIsWdt && !wrEn && pwrMode != 2'b11) |=> $stable(pinOut)); // R8

  AST_HW_STBY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (pwrMode == 2'b11) |=> pinOut == 15'd0); // R9
endmodule

bind gpio_port_data gpio_pdr_chk u_chk (
  .clk(clk), .rstN(rstN), .resetReq(resetReq), .resetIsWdt(resetIsWdt),
  .pwrMode(pwrMode), .wrEn(wrEn), .byteEn(byteEn), .wrData(wrData),
  .rdData(rdData), .dirBits(dirBits), .genFunc(genFunc),
  .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/sim_gpio_port_data.sv
`timescale 1ns/1ps
module sim_gpio_port_data;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetReq = 1'b0;
  logic        resetIsWdt = 1'b0;
  logic [1:0]  pwrMode = 2'b00;
  logic        wrEn = 1'b0;
  logic [1:0]  byteEn = 2'b00;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [14:0] pinIn = '0;
  logic [14:0] dirBits = '0;
  logic [14:0] genFunc = '0;
  logic [14:0] pinOut;
  logic [14:0] pinOe;

  int checks = 0;
  int errors = 0;
  logic [14:0] model = '0;

  always #2 clk = ~clk;

  gpio_port_data u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; byteEn = be; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; byteEn = 2'b00;
    if (be[0]) model[7:0]  = d[7:0];
    if (be[1]) model[14:8] = d[14:8];
  endtask

  function automatic logic [15:0] expRead(input logic [14:0] dir, input logic [14:0] pin);
    return {1'b1, (dir & model) | (~dir & pin)};
  endfunction

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    logic [15:0] pats [5];
    logic [14:0] last;
    pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'hA5C3;
    pats[3] = 16'h5A3C; pats[4] = 16'h7F01;

    idle(3);
    rstN = 1'b1;
    idle(3);
    // R1: reset value, input direction and output direction
    chk("R1", rdData, 16'h8000);
    chk("R1", {1'b0, pinOut}, 16'h0000);
    dirBits = '1;
    idle(1);
    chk("R1", rdData, 16'h8000);

    // R4 / R2: byte-lane sweep
    genFunc = '1;
    for (int be = 0; be < 4; be++) begin
      for (int p = 0; p < 5; p++) begin
        busWrite(be[1:0], pats[p]);
        chk("R4", rdData, {1'b1, model});
        chk("R2", {15'd0, rdData[15]}, 16'h0001);
        chk("R5", {1'b0, pinOut}, {1'b0, model});
        chk("R5", {1'b0, pinOe}, 16'h7FFF);
      end
    end

    // R3: per-pin source selection
    busWrite(2'b11, 16'h3C5A);
    pinIn = ~model;
    idle(3);
    for (int k = 0; k < 15; k++) begin
      dirBits = 15'h1 << k;
      idle(1);
      chk("R3", rdData, expRead(dirBits, pinIn));
      dirBits = ~(15'h1 << k);
      idle(1);
      chk("R3", rdData, expRead(dirBits, pinIn));
    end

    // R5: output enable gating
    for (int d = 0; d < 4; d++) begin
      for (int g = 0; g < 4; g++) begin
        dirBits = {pats[d][14:0]};
        genFunc = {pats[g + 1][14:0]};
        idle(1);
        chk("R5", {1'b0, pinOe}, {1'b0, dirBits & genFunc});
        chk("R5", {1'b0, pinOut}, {1'b0, model});
      end
    end

    // R6: writes while input or non-general still stored
    dirBits = '0; genFunc = '1;
    busWrite(2'b11, 16'h1234);
    chk("R6", {1'b0, pinOe}, 16'h0000);
    dirBits = '1; genFunc = '0;
    busWrite(2'b11, 16'hF0F0);
    chk("R6", {1'b0, pinOe}, 16'h0000);
    chk("R6", rdData, 16'hF0F0);
    dirBits = '0; genFunc = '1;
    busWrite(2'b11, 16'h1234);
    dirBits = '1;
    idle(1);
    chk("R6", rdData, 16'h9234);

    // R8: watchdog reset keeps
    @(negedge clk); resetReq = 1'b1; resetIsWdt = 1'b1;
    @(negedge clk); resetReq = 1'b0; resetIsWdt = 1'b0;
    chk("R8", rdData, 16'h9234);

    // R9: sleep and software standby keep
    pwrMode = 2'b01; idle(3);
    chk("R9", rdData, 16'h9234);
    pwrMode = 2'b10; idle(3);
    chk("R9", rdData, 16'h9234);
    pwrMode = 2'b00;

    // R7: non-watchdog reset clears
    @(negedge clk); resetReq = 1'b1;
    @(negedge clk); resetReq = 1'b0; model = '0;
    chk("R7", rdData, 16'h8000);
    chk("R7", {1'b0, pinOut}, 16'h0000);

    // R9: hardware standby clears
    busWrite(2'b11, 16'h7777);
    chk("R9", rdData, 16'hF777);
    @(negedge clk); pwrMode = 2'b11;
    @(negedge clk); pwrMode = 2'b00; model = '0;
    chk("R9", rdData, 16'h8000);

    // R10: clear beats a write in the same cycle
    @(negedge clk); resetReq = 1'b1; wrEn = 1'b1; byteEn = 2'b11; wrData = 16'h2AAA;
    @(negedge clk); resetReq = 1'b0; wrEn = 1'b0;
    chk("R10", rdData, 16'h8000);
    @(negedge clk); pwrMode = 2'b11; wrEn = 1'b1; wrData = 16'h1555;
    @(negedge clk); pwrMode = 2'b00; wrEn = 1'b0;
    chk("R10", rdData, 16'h8000);
    @(negedge clk); resetReq = 1'b1; resetIsWdt = 1'b1; wrEn = 1'b1; wrData = 16'h1555;
    @(negedge clk); resetReq = 1'b0; resetIsWdt = 1'b0; wrEn = 1'b0;
    chk("R10", rdData, 16'h9555);
    chk("R2", rdData & 16'h8000, 16'h8000);

    // R11: two-edge input latency
    dirBits = '0;
    pinIn = 15'h0000;
    idle(3);
    for (int t = 0; t < 3; t++) begin
      last = pinIn;
      pinIn = pats[t + 2][14:0];
      @(negedge clk);
      chk("R11", rdData, {1'b1, last});
      @(negedge clk);
      chk("R11", rdData, {1'b1, pinIn});
    end

    finish();
  end
endmodule